// File: doc/BRIEF.md
# Up/Down Route Selector with Wireless Shortcuts

This unit computes the output port for packets in one switch of an irregular, small-world network-on-chip. Deadlock freedom comes from a spanning tree. Every inter-switch wired port is classed in one of four ways: a tree link toward the root, a tree link away from the root, a wired link outside the tree (a shortcut), or not connected. One further port leads to the local wireless interface.

Each packet header carries a one-bit phase flag. The flag is 0 while the packet is still climbing the tree and 1 once it has turned down. For a head flit, the unit looks up the destination's row in a hop-count table. It keeps only the wired ports that are legal in the current phase and picks the one with the fewest hops. The wireless port replaces that choice only when the local interface holds the channel token and the wireless hop count is strictly smaller. The chosen port and the updated flag come out of a register one cycle later. Body and tail flits reuse the port their head locked.

The hop-count table is filled through a simple write port. Each write carries a destination, a port index and a hop count.

Top module: `route_sel_updown`

## Requirements
- R1: Every cycle with `flit_valid_i` high is answered one cycle later by `rt_valid_o` high. `rt_head_o` copies the flit's head bit. A cycle without a flit gives `rt_valid_o` low one cycle later.
- R2: A head flit whose destination equals `my_id_i` is routed to port 0 (the local core) with `rt_ok_o` = 1, and the phase flag passes through unchanged.
- R3: A wired port of class up (code 0 in `port_kind_i`) is legal only while the incoming phase flag is 0. A packet in the down phase never leaves on an up port.
- R4: The outgoing flag stays 0 only when an up port is chosen from the up phase. Choosing a down port (code 1), a wired shortcut (code 2) or the wireless port sets it to 1. A flag that arrives as 1 leaves as 1.
- R5: Among the legal wired ports, the one with the smallest table hop count wins, and ties go to the lowest port index. Wired ports occupy indices 1..KMAX, and port i takes its class from bits [2i-1:2i-2] of `port_kind_i`. The all-ones hop value means "no path". Class code 3 marks an unconnected port that is never chosen.
- R6: The wireless port (index KMAX+1) is chosen only while `wl_token_i` is high.
- R7: The wireless port is chosen only if its hop count is strictly below the best legal wired hop count. On a tie, the wired port wins. When no wired port is legal, any finite wireless hop count qualifies.
- R8: When no port is legal, the result has `rt_ok_o` = 0 and port 0, and the phase flag is unchanged.
- R9: A non-head flit is routed to the port, flag and ok value locked by the most recent head flit. Its own destination, flag and the token are ignored.
- R10: A table write sets the hop count for one (destination, port) entry at the clock edge. The next head flit to that destination sees the new value.
- R11: While reset is active and after it is released, `rt_valid_o` and `rt_ok_o` are 0 until a flit arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id_i | input | IDW | ID of this switch |
| port_kind_i | input | 2*KMAX | Class code per wired port (0 up, 1 down, 2 shortcut, 3 open) |
| flit_valid_i | input | 1 | A flit is presented |
| flit_head_i | input | 1 | The flit is a head flit |
| flit_dest_i | input | IDW | Destination switch ID from the header |
| flit_phase_i | input | 1 | Header phase flag (0 up, 1 down) |
| wl_token_i | input | 1 | Local wireless interface holds the channel token |
| tbl_wr_en_i | input | 1 | Table write strobe |
| tbl_wr_dest_i | input | IDW | Destination row to write |
| tbl_wr_port_i | input | PORTW | Port column to write (1..KMAX+1) |
| tbl_wr_hops_i | input | HOPW | Hop count to store |
| rt_valid_o | output | 1 | Route result valid |
| rt_head_o | output | 1 | Result belongs to a head flit |
| rt_port_o | output | PORTW | Selected output port |
| rt_phase_o | output | 1 | Updated phase flag |
| rt_ok_o | output | 1 | A legal port was found |

## Verification
The bench builds the unit with eight switches, four wired ports and 4-bit hop counts. That is small enough to give one port of each class (up, down, shortcut, open) plus the wireless port at index 5. Hop value 15 serves as the unreachable marker. With this setup, hand-computed rows reach every selection outcome: up-versus-down legality by phase, index tie-break, wireless ties and wins with and without token, empty candidate sets, and the local destination. Directed steps then cover the head-locked body flits and a table rewrite that changes a route.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
  typedef enum logic [1:0] {
    PK_UP    = 2'd0,
    PK_DOWN  = 2'd1,
    PK_SHORT = 2'd2,
    PK_OPEN  = 2'd3
  } port_kind_e;
endpackage

// File: rtl/route_hop_table.sv
module route_hop_table #(
  parameter int NODES = 16,
  parameter int NPORT = 9,
  parameter int HOPW  = 4,
  localparam int IDW   = $clog2(NODES),
  localparam int PORTW = $clog2(NPORT)
) (
  input  logic                   clk,
  input  logic                   wr_en_i,
  input  logic [IDW-1:0]         wr_dest_i,
  input  logic [PORTW-1:0]       wr_port_i,
  input  logic [HOPW-1:0]        wr_hops_i,
  input  logic [IDW-1:0]         rd_dest_i,
  output logic [NPORT*HOPW-1:0]  row_o
);
  logic [HOPW-1:0] hop_q [NODES][NPORT];
  logic            wr_hit;

  always_comb begin
    wr_hit = wr_en_i && (wr_port_i != '0) && (32'(wr_port_i) < NPORT);
  end

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      hop_q[wr_dest_i][wr_port_i] <= wr_hops_i;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_row
    assign row_o[p*HOPW +: HOPW] = hop_q[rd_dest_i][p];
  end
endmodule

// File: rtl/route_pick.sv
module route_pick
  import route_sel_pkg::*;
#(
  parameter int KMAX = 7,
  parameter int HOPW = 4,
  localparam int NPORT = KMAX + 2,
  localparam int PORTW = $clog2(NPORT),
  localparam int WL    = KMAX + 1
) (
  input  logic [NPORT*HOPW-1:0] row_i,
  input  logic [2*KMAX-1:0]     kinds_i,
  input  logic                  phase_i,
  input  logic                  token_i,
  output logic [PORTW-1:0]      port_o,
  output logic                  phase_o,
  output logic                  ok_o
);
  logic [HOPW-1:0]  best_hop;
  logic [PORTW-1:0] best_idx;
  logic             best_up;
  logic [HOPW-1:0]  wl_hop;
  logic             take_wl;
  port_kind_e       kind;
  logic [HOPW-1:0]  hop;
  logic             legal;

  always_comb begin
    best_hop = '1;
    best_idx = '0;
    best_up  = 1'b0;
    kind     = PK_OPEN;
    hop      = '1;
    legal    = 1'b0;
    for (int i = 1; i <= KMAX; i++) begin
      kind  = port_kind_e'(kinds_i[2*(i-1) +: 2]);
      hop   = row_i[i*HOPW +: HOPW];
      legal = (kind == PK_DOWN) || (kind == PK_SHORT) ||
              ((kind == PK_UP) && !phase_i);
      if (legal && (hop < best_hop)) begin
        best_hop = hop;
        best_idx = PORTW'(i);
        best_up  = (kind == PK_UP);
      end
    end
    wl_hop  = row_i[WL*HOPW +: HOPW];
    take_wl = token_i && (wl_hop < best_hop);
    if (take_wl) begin
      port_o  = PORTW'(WL);
      phase_o = 1'b1;
      ok_o    = 1'b1;
    end else if (best_hop != '1) begin
      port_o  = best_idx;
      phase_o = best_up ? phase_i : 1'b1;
      ok_o    = 1'b1;
    end else begin
      port_o  = '0;
      phase_o = phase_i;
      ok_o    = 1'b0;
    end
  end
endmodule

// File: rtl/route_sel_updown.sv
module route_sel_updown #(
  parameter int NODES = 16,
  parameter int KMAX  = 7,
  parameter int HOPW  = 4,
  localparam int IDW   = $clog2(NODES),
  localparam int NPORT = KMAX + 2,
  localparam int PORTW = $clog2(NPORT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDW-1:0]     my_id_i,
  input  logic [2*KMAX-1:0]  port_kind_i,
  input  logic               flit_valid_i,
  input  logic               flit_head_i,
  input  logic [IDW-1:0]     flit_dest_i,
  input  logic               flit_phase_i,
  input  logic               wl_token_i,
  input  logic               tbl_wr_en_i,
  input  logic [IDW-1:0]     tbl_wr_dest_i,
  input  logic [PORTW-1:0]   tbl_wr_port_i,
  input  logic [HOPW-1:0]    tbl_wr_hops_i,
  output logic               rt_valid_o,
  output logic               rt_head_o,
  output logic [PORTW-1:0]   rt_port_o,
  output logic               rt_phase_o,
  output logic               rt_ok_o
);
  logic                  rst_meta_q, rst_q_n;
  logic [NPORT*HOPW-1:0] row;
  logic [PORTW-1:0]      pick_port;
  logic                  pick_phase, pick_ok;

  logic                  valid_d, valid_q, head_d, head_q;
  logic [PORTW-1:0]      port_d, port_q, lock_port_d, lock_port_q;
  logic                  phase_d, phase_q, lock_phase_d, lock_phase_q;
  logic                  ok_d, ok_q, lock_ok_d, lock_ok_q;
  logic                  head_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  route_hop_table #(.NODES(NODES), .NPORT(NPORT), .HOPW(HOPW)) u_table (
    .clk      (clk),
    .wr_en_i  (tbl_wr_en_i),
    .wr_dest_i(tbl_wr_dest_i),
    .wr_port_i(tbl_wr_port_i),
    .wr_hops_i(tbl_wr_hops_i),
    .rd_dest_i(flit_dest_i),
    .row_o    (row)
  );

  route_pick #(.KMAX(KMAX), .HOPW(HOPW)) u_pick (
    .row_i  (row),
    .kinds_i(port_kind_i),
    .phase_i(flit_phase_i),
    .token_i(wl_token_i),
    .port_o (pick_port),
    .phase_o(pick_phase),
    .ok_o   (pick_ok)
  );

  always_comb begin
    head_en      = flit_valid_i && flit_head_i;
    valid_d      = flit_valid_i;
    head_d       = flit_valid_i && flit_head_i;
    lock_port_d  = lock_port_q;
    lock_phase_d = lock_phase_q;
    lock_ok_d    = lock_ok_q;
    if (head_en) begin
      if (flit_dest_i == my_id_i) begin
        lock_port_d  = '0;
        lock_phase_d = flit_phase_i;
        lock_ok_d    = 1'b1;
      end else begin
        lock_port_d  = pick_port;
        lock_phase_d = pick_phase;
        lock_ok_d    = pick_ok;
      end
    end
    port_d  = port_q;
    phase_d = phase_q;
    ok_d    = 1'b0;
    if (flit_valid_i) begin
      port_d  = lock_port_d;
      phase_d = lock_phase_d;
      ok_d    = lock_ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q      <= 1'b0;
      head_q       <= 1'b0;
      port_q       <= '0;
      phase_q      <= 1'b0;
      ok_q         <= 1'b0;
      lock_port_q  <= '0;
      lock_phase_q <= 1'b0;
      lock_ok_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      head_q  <= head_d;
      ok_q    <= ok_d;
      if (flit_valid_i) begin
        port_q  <= port_d;
        phase_q <= phase_d;
      end
      if (head_en) begin
        lock_port_q  <= lock_port_d;
        lock_phase_q <= lock_phase_d;
        lock_ok_q    <= lock_ok_d;
      end
    end
  end

  assign rt_valid_o = valid_q;
  assign rt_head_o  = head_q;
  assign rt_port_o  = port_q;
  assign rt_phase_o = phase_q;
  assign rt_ok_o    = ok_q;
endmodule

// File: rtl/route_sel_checker.sv
module route_sel_checker #(
  parameter int NODES = 16,
  parameter int KMAX  = 7,
  localparam int IDW   = $clog2(NODES),
  localparam int NPORT = KMAX + 2,
  localparam int PORTW = $clog2(NPORT),
  localparam int WL    = KMAX + 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [IDW-1:0]    my_id_i,
  input logic [2*KMAX-1:0] port_kind_i,
  input logic              flit_valid_i,
  input logic              flit_head_i,
  input logic [IDW-1:0]    flit_dest_i,
  input logic              flit_phase_i,
  input logic              wl_token_i,
  input logic              rt_valid_o,
  input logic              rt_head_o,
  input logic [PORTW-1:0]  rt_port_o,
  input logic              rt_phase_o,
  input logic              rt_ok_o
);
  logic out_is_up;
  always_comb begin
    out_is_up = 1'b0;
    for (int i = 1; i <= KMAX; i++) begin
      if ((32'(rt_port_o) == i) && (port_kind_i[2*(i-1) +: 2] == 2'd0)) out_is_up = 1'b1;
    end
  end

  a_r1_answer: assert property (@(posedge clk) disable iff (!rst_q_n)
    flit_valid_i |=> rt_valid_o && (rt_head_o == $past(flit_head_i)));
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !flit_valid_i |=> !rt_valid_o);
  a_r2_local: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flit_valid_i && flit_head_i && flit_dest_i == my_id_i) |=>
      (rt_port_o == '0) && rt_ok_o && (rt_phase_o == $past(flit_phase_i)));
  a_r3_no_up_after_down: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flit_valid_i && flit_head_i && flit_phase_i) |=> !(rt_ok_o && out_is_up));
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flit_valid_i && flit_head_i && flit_phase_i) |=> rt_phase_o);
  a_r6_token_needed: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flit_valid_i && flit_head_i && !wl_token_i) |=> (32'(rt_port_o) != WL));
  a_r8_fail_port: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rt_valid_o && !rt_ok_o) |-> (rt_port_o == '0));
  a_r9_body_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flit_valid_i && !flit_head_i && rt_valid_o) |=> $stable(rt_port_o));
endmodule

bind route_sel_updown route_sel_checker #(.NODES(NODES), .KMAX(KMAX)) u_checker (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .my_id_i     (my_id_i),
  .port_kind_i (port_kind_i),
  .flit_valid_i(flit_valid_i),
  .flit_head_i (flit_head_i),
  .flit_dest_i (flit_dest_i),
  .flit_phase_i(flit_phase_i),
  .wl_token_i  (wl_token_i),
  .rt_valid_o  (rt_valid_o),
  .rt_head_o   (rt_head_o),
  .rt_port_o   (rt_port_o),
  .rt_phase_o  (rt_phase_o),
  .rt_ok_o     (rt_ok_o)
);

// File: tb/test_route_sel_updown.sv
`timescale 1ns/1ps
module test_route_sel_updown;
  localparam int NODES = 8;
  localparam int KMAX  = 4;
  localparam int HOPW  = 4;
  localparam int IDW   = 3;
  localparam int PORTW = 3;

  logic             clk, rst_n;
  logic [IDW-1:0]   my_id;
  logic [2*KMAX-1:0] kinds;
  logic             fv, fh, fph, tok;
  logic [IDW-1:0]   fd;
  logic             we;
  logic [IDW-1:0]   wd;
  logic [PORTW-1:0] wp;
  logic [HOPW-1:0]  wh;
  logic             rv, rh, rph, rok;
  logic [PORTW-1:0] rp;
  int total = 0, bad = 0;
  bit done = 0;

  route_sel_updown #(.NODES(NODES), .KMAX(KMAX), .HOPW(HOPW)) i_route_sel_updown (
    .clk(clk), .rst_n(rst_n), .my_id_i(my_id), .port_kind_i(kinds),
    .flit_valid_i(fv), .flit_head_i(fh), .flit_dest_i(fd), .flit_phase_i(fph),
    .wl_token_i(tok), .tbl_wr_en_i(we), .tbl_wr_dest_i(wd), .tbl_wr_port_i(wp),
    .tbl_wr_hops_i(wh), .rt_valid_o(rv), .rt_head_o(rh), .rt_port_o(rp),
    .rt_phase_o(rph), .rt_ok_o(rok)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // {dest[2:0], phase, token, exp_port[2:0], exp_phase, exp_ok}
  localparam logic [9:0] VEC [12] = '{
    {3'd1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1},  // R3 R5 up legal in up phase
    {3'd1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1},  // R3 R5 tie -> lower index
    {3'd2, 1'b0, 1'b1, 3'd5, 1'b1, 1'b1},  // R7 wireless shorter
    {3'd2, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1},  // R6 no token
    {3'd3, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1},  // R7 equal -> wired
    {3'd3, 1'b1, 1'b1, 3'd5, 1'b1, 1'b1},  // R7 only wireless
    {3'd3, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0},  // R8 none, flag kept
    {3'd4, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0},  // R8 all unreachable
    {3'd5, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1},  // R4 up keeps 0
    {3'd5, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1},  // R4 down sets 1
    {3'd0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1},  // R2 local
    {3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1}   // R2 local
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int d, input int p, input int h);
    @(negedge clk);
    we = 1; wd = IDW'(d); wp = PORTW'(p); wh = HOPW'(h);
    @(negedge clk);
    we = 0;
  endtask

  task automatic flit(input bit head, input int d, input bit ph, input bit tk);
    @(negedge clk);
    fv = 1; fh = head; fd = IDW'(d); fph = ph; tok = tk;
    @(posedge clk); #1;
  endtask

  task automatic row(input int d, input int h1, input int h2, input int h3, input int h4, input int h5);
    wr(d, 1, h1); wr(d, 2, h2); wr(d, 3, h3); wr(d, 4, h4); wr(d, 5, h5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; my_id = 0; kinds = {2'd3, 2'd2, 2'd1, 2'd0};
    fv = 0; fh = 0; fd = 0; fph = 0; tok = 0; we = 0; wd = 0; wp = 0; wh = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R11 valid in reset", int'(rv), 0);
    check("R11 ok in reset", int'(rok), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 valid after reset", int'(rv), 0);
    check("R11 ok after reset", int'(rok), 0);

    for (int d = 0; d < NODES; d++) row(d, 15, 15, 15, 15, 15);
    row(1, 2, 3, 3, 1, 15);
    row(2, 5, 4, 2, 15, 1);
    row(3, 3, 15, 15, 15, 3);
    row(5, 1, 1, 1, 1, 15);

    for (int v = 0; v < 12; v++) begin
      flit(1'b1, int'(VEC[v][9:7]), VEC[v][6], VEC[v][5]);
      check("R1 valid", int'(rv), 1);
      check("R1 head", int'(rh), 1);
      check("R5 R7 port", int'(rp), int'(VEC[v][4:2]));
      check("R4 phase", int'(rph), int'(VEC[v][1]));
      check("R8 ok", int'(rok), int'(VEC[v][0]));
    end

    // R1 idle cycle
    @(negedge clk); fv = 0;
    @(posedge clk); #1;
    check("R1 idle", int'(rv), 0);

    // R9 body flits follow locked head
    flit(1'b1, 2, 1'b0, 1'b1);
    check("R9 head port", int'(rp), 5);
    flit(1'b0, 1, 1'b1, 1'b0);
    check("R9 body port", int'(rp), 5);
    check("R9 body head bit", int'(rh), 0);
    check("R9 body phase", int'(rph), 1);
    flit(1'b0, 4, 1'b0, 1'b0);
    check("R9 tail port", int'(rp), 5);
    check("R9 tail ok", int'(rok), 1);
    @(negedge clk); fv = 0;

    // R10 table rewrite changes choice
    wr(1, 3, 1);
    flit(1'b1, 1, 1'b0, 1'b0);
    check("R10 rewritten port", int'(rp), 3);
    check("R10 rewritten phase", int'(rph), 1);
    @(negedge clk); fv = 0;

    // R3 up port excluded in down phase even when strictly best
    wr(6, 1, 1); wr(6, 2, 9);
    flit(1'b1, 6, 1'b1, 1'b0);
    check("R3 down phase skips up", int'(rp), 2);
    @(negedge clk); fv = 0;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule